// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two operands held in signed-magnitude form. Each operand is a magnitude register with its own sign bit. One parallel adder does all the arithmetic. A complementer in front of it passes the second magnitude unchanged or inverted, and the mode bit also drives the carry-in. The carry-out of every adder pass goes into a flag bit, and the result magnitude goes back into the first operand register.

After a magnitude subtraction, the control logic reads the carry flag. If it shows that the second magnitude was the larger one, the control makes one more pass. That pass replaces the result with its two's complement and inverts the result sign. An overflow flag records the carry of a magnitude addition. A final pass clears the sign of a zero result.

To use the block, load the operands while it is idle, then pulse start with the add/subtract select. Wait for the one-cycle done pulse, then read the result magnitude, result sign and overflow.

Top module: `sm_addsub_unit`

## Requirements
- R1: After reset, resMag is 0, resSign is 0, overflow is 0 and done is 0.
- R2: While the unit is idle, a high load copies aMagIn, aSignIn, bMagIn and bSignIn into the operand registers at the clock edge. From the next cycle, resMag shows aMagIn and resSign shows aSignIn.
- R3: The magnitudes are added when opSub=0 (add) and the signs are equal, or when opSub=1 (subtract) and the signs differ. In that case:
  - resMag is (|A|+|B|) mod 2^WIDTH.
  - resSign is the sign of A.
  - overflow is the carry-out of that sum.
- R4: In every other sign/operation combination the magnitudes are subtracted. If |A| >= |B|, resMag is |A|-|B|, resSign is the sign of A, and overflow is 0.
- R5: On a magnitude subtraction with |A| < |B|, resMag is |B|-|A|, resSign is the inverse of the sign of A, and overflow is 0.
- R6: Whenever the final resMag is 0, resSign is 0. This includes an addition that wraps to zero.
- R7: If start is sampled high at an idle clock edge, done is high in the fourth cycle after that edge. It stays high for exactly one cycle. The results are valid in that cycle.
- R8: From the edge that accepts start up to and including the done cycle, the unit ignores start and load.
- R9: Load and start may be high in the same idle cycle. The operation then uses the operands loaded at that edge.
- R10: While idle and with neither load nor start high, resMag, resSign and overflow hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture both operands (idle only) |
| aMagIn | input | WIDTH | Magnitude of operand A |
| aSignIn | input | 1 | Sign of operand A, 1 = negative |
| bMagIn | input | WIDTH | Magnitude of operand B |
| bSignIn | input | 1 | Sign of operand B, 1 = negative |
| start | input | 1 | Begin an operation (idle only) |
| opSub | input | 1 | Operation select sampled with start: 0 add, 1 subtract |
| resMag | output | WIDTH | Result magnitude (the A register) |
| resSign | output | 1 | Result sign |
| overflow | output | 1 | Carry of a magnitude addition |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can collide in one cycle: an operand load and the start of an operation. They may arrive together in an idle cycle, or start and load may both arrive during the busy and done cycles. The bench sweeps every magnitude, sign and operation of a 4-bit configuration through three patterns: load before start, load and start together, and a held start plus a garbage load across the whole busy window into the done cycle. Each pattern is judged against arithmetic reference values, the fixed four-cycle latency and the absence of a second done pulse. A wrongly accepted load or start shows up as a wrong magnitude, a wrong sign or an extra done.

// File: rtl/sm_pkg.sv
package sm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_CHECK,
    ST_NORM,
    ST_DONE
  } smState_t;

  typedef struct packed {
    logic loadOps;
    logic latchOp;
    logic doExec;
    logic doFix;
    logic doNorm;
  } smStrobes_t;

endpackage

// File: rtl/sm_complementer.sv
module sm_complementer #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bIn,
  input  logic             invert,
  output logic [WIDTH-1:0] bOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bOut[i] = bIn[i] ^ invert;
  end
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
  import sm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  smStrobes_t       strobes,
  input  logic [WIDTH-1:0] aMagIn,
  input  logic             aSignIn,
  input  logic [WIDTH-1:0] bMagIn,
  input  logic             bSignIn,
  input  logic             opSub,
  output logic             magSub,
  output logic             eFlag,
  output logic [WIDTH-1:0] aMag,
  output logic             aSign,
  output logic             avf
);
  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] bMag;
  logic             bSign;
  logic             opReg;
  logic [WIDTH-1:0] bOperand;
  logic [SUMW-1:0]  sumFull;
  logic [WIDTH-1:0] aNeg;

  assign magSub = aSign ^ bSign ^ opReg;

  sm_complementer #(.WIDTH(WIDTH)) u_comp (
    .bIn   (bMag),
    .invert(magSub),
    .bOut  (bOperand)
  );

  assign sumFull = {1'b0, aMag} + {1'b0, bOperand} + {{WIDTH{1'b0}}, magSub};
  assign aNeg    = ~aMag + {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aMag  <= '0;
      bMag  <= '0;
      aSign <= 1'b0;
      bSign <= 1'b0;
      eFlag <= 1'b0;
      avf   <= 1'b0;
      opReg <= 1'b0;
    end else begin
      if (strobes.loadOps) begin
        aMag  <= aMagIn;
        aSign <= aSignIn;
        bMag  <= bMagIn;
        bSign <= bSignIn;
      end
      if (strobes.latchOp) opReg <= opSub;
      if (strobes.doExec) begin
        {eFlag, aMag} <= sumFull;
        avf           <= magSub ? 1'b0 : sumFull[WIDTH];
      end
      if (strobes.doFix) begin
        aMag  <= aNeg;
        aSign <= ~aSign;
      end
      if (strobes.doNorm && (aMag == '0)) aSign <= 1'b0;
    end
  end
endmodule

// File: rtl/sm_control.sv
module sm_control
  import sm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       start,
  input  logic       magSub,
  input  logic       eFlag,
  output smStrobes_t strobes,
  output logic       busy,
  output logic       done
);
  smState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        strobes.loadOps = load;
        strobes.latchOp = start;
        if (start) stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        strobes.doExec = 1'b1;
        stateNext      = ST_CHECK;
      end
      ST_CHECK: begin
        strobes.doFix = magSub & ~eFlag;
        stateNext     = ST_NORM;
      end
      ST_NORM: begin
        strobes.doNorm = 1'b1;
        stateNext      = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/sm_addsub_unit.sv
module sm_addsub_unit
  import sm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] aMagIn,
  input  logic             aSignIn,
  input  logic [WIDTH-1:0] bMagIn,
  input  logic             bSignIn,
  input  logic             start,
  input  logic             opSub,
  output logic [WIDTH-1:0] resMag,
  output logic             resSign,
  output logic             overflow,
  output logic             done
);
  smStrobes_t strobes;
  logic       magSub;
  logic       eFlag;
  logic       busy;

  sm_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .load   (load),
    .start  (start),
    .magSub (magSub),
    .eFlag  (eFlag),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  sm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .aMagIn (aMagIn),
    .aSignIn(aSignIn),
    .bMagIn (bMagIn),
    .bSignIn(bSignIn),
    .opSub  (opSub),
    .magSub (magSub),
    .eFlag  (eFlag),
    .aMag   (resMag),
    .aSign  (resSign),
    .avf    (overflow)
  );
endmodule

// File: rtl/sm_addsub_unit_checker.sv
module sm_addsub_unit_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             load,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] resMag,
  input logic             resSign,
  input logic             overflow
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_accepted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_no_negative_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(resSign && (resMag == '0)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !load && !start) |=>
      ($stable(resMag) && $stable(resSign) && $stable(overflow)));

  assert_busy_ignores_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && load) |=> ($stable(resMag) && $stable(resSign)));
endmodule

bind sm_addsub_unit sm_addsub_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .load    (load),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .resMag  (resMag),
  .resSign (resSign),
  .overflow(overflow)
);

// File: tb/sm_addsub_unit_bench.sv
module sm_addsub_unit_bench;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] aMagIn = '0;
  logic         aSignIn = 1'b0;
  logic [W-1:0] bMagIn = '0;
  logic         bSignIn = 1'b0;
  logic         start = 1'b0;
  logic         opSub = 1'b0;
  logic [W-1:0] resMag;
  logic         resSign;
  logic         overflow;
  logic         done;

  int nCmp = 0;
  int nBad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sm_addsub_unit #(.WIDTH(W)) u_sm_addsub_unit (
    .clk(clk), .rstN(rstN), .load(load), .aMagIn(aMagIn), .aSignIn(aSignIn),
    .bMagIn(bMagIn), .bSignIn(bSignIn), .start(start), .opSub(opSub),
    .resMag(resMag), .resSign(resSign), .overflow(overflow), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic runOp(input int a, input bit as, input int b, input bit bs,
                       input bit op, input int mode);
    int     expMag, sum, lat;
    bit     expSign, expOv, magSubE, seen;
    string  tag;
    magSubE = as ^ bs ^ op;
    if (!magSubE) begin
      sum = a + b; expMag = sum & MAXV; expOv = (sum > MAXV); expSign = as; tag = "R3";
    end else if (a >= b) begin
      expMag = a - b; expOv = 1'b0; expSign = as; tag = "R4";
    end else begin
      expMag = b - a; expOv = 1'b0; expSign = ~as; tag = "R5";
    end
    if (expMag == 0) expSign = 1'b0;

    @(negedge clk);
    load = 1'b1; aMagIn = W'(a); aSignIn = as; bMagIn = W'(b); bSignIn = bs;
    opSub = op; start = (mode == 1);
    if (mode != 1) begin
      @(negedge clk);
      load = 1'b0;
      chk(resMag == W'(a) && resSign == as, "R2 load", resMag, a);
      start = 1'b1;
    end
    lat = 0; seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        if (mode == 2) begin
          load = 1'b1; aMagIn = ~W'(a); aSignIn = ~as;
          bMagIn = ~W'(b); bSignIn = ~bs; opSub = ~op; start = 1'b1;
        end else begin
          load = 1'b0; start = 1'b0;
        end
      end
      if (done) seen = 1'b1;
    end
    chk(seen && lat == 4, "R7 latency", lat, 4);
    chk(resMag == W'(expMag), (mode == 1) ? "R9 mag" : (mode == 2) ? "R8 mag" : {tag, " mag"}, resMag, expMag);
    chk(resSign == expSign, (expMag == 0) ? "R6 sign" : {tag, " sign"}, resSign, expSign);
    chk(overflow == expOv, {tag, " overflow"}, overflow, expOv);
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    chk(!done, "R7 single pulse", done, 0);
    if (mode == 2) begin
      chk(resMag == W'(expMag) && resSign == expSign, "R8 load in done cycle", resMag, expMag);
      seen = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      chk(!seen, "R8 start ignored", seen, 0);
      chk(resMag == W'(expMag) && resSign == expSign && overflow == expOv,
          "R10 hold", resMag, expMag);
    end
  endtask

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    chk(resMag == 0, "R1 resMag", resMag, 0);
    chk(resSign == 0, "R1 resSign", resSign, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(done == 0, "R1 done", done, 0);
    rstN = 1'b1;
    idx = 0;
    for (int a = 0; a <= MAXV; a++)
      for (int b = 0; b <= MAXV; b++)
        for (int s = 0; s < 8; s++) begin
          runOp(a, s[0], b, s[1], s[2], idx % 3);
          idx++;
        end
    // wrap-to-zero boundary and equal-magnitude subtract
    runOp(8, 1'b1, 8, 1'b1, 1'b0, 2);
    runOp(MAXV, 1'b0, MAXV, 1'b0, 1'b1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule